// File: doc/BRIEF.md
# I2C SCL timing generator

This block produces the serial-clock timing of an I2C master from the peripheral clock. A single clock-control count sets both phase lengths. Three ratios are available: a symmetric standard-mode ratio, and 2:1 or 16:9 low-to-high ratios for fast mode and fast mode plus. Each mode has its own minimum count. The block requests an open-drain pull-down of SCL for the low phase and releases the line for the high phase.

During the released phase the block allows a programmable rise-time budget. After that budget, a slave that holds SCL low stretches the phase. Two single-cycle strobes tell a byte engine when to change SDA and when to sample it. START/STOP sequencing, shifting and addressing are handled elsewhere.

Top module: `i2c_scl_timer`

## Requirements
- R1: With `fast_i`=0, the low phase and the released phase each last max(`clkc_i`,4) cycles, whatever the value of `duty_i`.
- R2: With `fast_i`=1 and `duty_i`=0, the low phase lasts 2·c cycles and the released phase lasts c cycles, where c = max(`clkc_i`,1).
- R3: With `fast_i`=1 and `duty_i`=1, the low phase lasts 16·c cycles and the released phase lasts 9·c cycles, where c = max(`clkc_i`,1).
- R4: `fmp_i`=1 together with `fast_i`=1 gives the same timing as fast mode (R2/R3). `fmp_i`=1 with `fast_i`=0 has no effect, so the timing is standard timing (R1).
- R5: After `en_i` rises, `scl_low_o` first asserts in the second enabled cycle, which follows exactly one clock edge. Low and released phases then alternate, starting with a full low phase.
- R6: `sda_change_o` is high in the second cycle of every low phase and in no other cycle.
- R7: `sda_sample_o` is high in the first cycle of every released phase and in no other cycle.
- R8: The released-phase counter advances unconditionally during its first `rise_i` cycles. After that it advances only in cycles where `scl_i` is sampled high. If SCL is held low for the first L released cycles, the released phase lasts H+(L−`rise_i`) cycles when L>`rise_i` and H>`rise_i`, and H cycles otherwise.
- R9: While `en_i` is low, `scl_low_o`, `sda_change_o` and `sda_sample_o` are all low in that same cycle and the internal counters return to idle. This also holds after reset.
- R10: The largest `clkc_i` value produces the exact phase lengths in every mode, with no wrap of the 16·c product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| clkc_i | input | CNT_W | Clock-control count |
| fast_i | input | 1 | Fast-mode select |
| duty_i | input | 1 | Fast-mode duty select: 0 = 2:1, 1 = 16:9 |
| fmp_i | input | 1 | Fast-mode-plus enable |
| rise_i | input | RT_W | Rise-time budget in cycles (clamped to 127) |
| scl_i | input | 1 | Sampled SCL line |
| scl_low_o | output | 1 | Request to pull SCL low |
| sda_change_o | output | 1 | Strobe: SDA may change |
| sda_sample_o | output | 1 | Strobe: SDA may be sampled |

## Verification
`scl_low_o` rises one clock edge after `en_i` is raised. It falls in the same cycle that `en_i` drops, because the outputs are gated by the enable. The strobes are decoded from registered phase state, so each one is due in the cycle its phase begins (sample) or in the cycle after (change). The bench changes inputs just after a rising edge and samples every output at the falling edge. It measures the length of each low and released run against lengths computed from R1–R4 and R8, and it checks each strobe against its run position. Runs cut short by a disable are never measured.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int STD_MIN_CNT = 4;
  localparam int RISE_CAP    = 127;

  typedef enum logic [1:0] {MODE_STD, MODE_FAST, MODE_FMP} scl_mode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_REL} scl_phase_e;

  function automatic scl_mode_e mode_decode(input logic fast, input logic fmp);
    if (!fast) return MODE_STD;
    return fmp ? MODE_FMP : MODE_FAST;
  endfunction
endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int LEN_W = CNT_W + 5
) (
  input  logic [CNT_W-1:0] clkc_i,
  input  logic             fast_i,
  input  logic             duty_i,
  input  logic             fmp_i,
  output logic [LEN_W-1:0] low_len_o,
  output logic [LEN_W-1:0] high_len_o
);
  scl_mode_e        mode;
  logic [LEN_W-1:0] c_std, c_fast;

  always_comb begin
    mode   = mode_decode(fast_i, fmp_i);
    c_std  = (clkc_i < CNT_W'(STD_MIN_CNT)) ? LEN_W'(STD_MIN_CNT) : LEN_W'(clkc_i);
    c_fast = (clkc_i == '0) ? LEN_W'(1) : LEN_W'(clkc_i);
    unique case (mode)
      MODE_FAST, MODE_FMP: begin
        if (duty_i) begin
          low_len_o  = c_fast << 4;
          high_len_o = (c_fast << 3) + c_fast;
        end else begin
          low_len_o  = c_fast << 1;
          high_len_o = c_fast;
        end
      end
      default: begin
        low_len_o  = c_std;
        high_len_o = c_std;
      end
    endcase
  end

  always_comb begin
    if (!fast_i)
      AST_STD_SYM: assert (low_len_o == high_len_o && low_len_o >= LEN_W'(STD_MIN_CNT)); // R1
    if (fast_i && !duty_i)
      AST_FAST_RATIO: assert (low_len_o == (high_len_o << 1) && high_len_o != '0); // R2
  end
endmodule

// File: rtl/scl_rise_budget.sv
module scl_rise_budget
  import i2c_scl_pkg::*;
#(
  parameter int RT_W  = 7,
  parameter int LEN_W = 17
) (
  input  logic [RT_W-1:0]  rise_i,
  output logic [LEN_W-1:0] rise_lim_o
);
  // clamp only when the port can express more than the cap
  if (RT_W > 7) begin : g_clamp
    always_comb
      rise_lim_o = (rise_i > RT_W'(RISE_CAP)) ? LEN_W'(RISE_CAP) : LEN_W'(rise_i);
  end else begin : g_pass
    always_comb rise_lim_o = LEN_W'(rise_i);
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import i2c_scl_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             scl_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic [LEN_W-1:0] rise_lim_i,
  output logic             drive_low_o,
  output logic             change_o,
  output logic             sample_o
);
  scl_phase_e       phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic             first_q;
  logic             adv;

  assign adv = scl_i || (cnt_q <= rise_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= 1'b0;
      unique case (phase_q)
        PH_LOW: begin
          if (cnt_q >= low_len_i) begin
            phase_q <= PH_REL;
            cnt_q   <= LEN_W'(1);
            first_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_REL: begin
          if (adv) begin
            if (cnt_q >= high_len_i) begin
              phase_q <= PH_LOW;
              cnt_q   <= LEN_W'(1);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          phase_q <= PH_LOW;
          cnt_q   <= LEN_W'(1);
        end
      endcase
    end
  end

  assign drive_low_o = en_i && (phase_q == PH_LOW);
  assign change_o    = en_i && (phase_q == PH_LOW) && (cnt_q == LEN_W'(2));
  assign sample_o    = en_i && (phase_q == PH_REL) && first_q;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == PH_IDLE && cnt_q == '0)); // R9
  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase_q == PH_LOW) |-> (cnt_q != '0 && cnt_q <= low_len_i)); // R1
  AST_CHANGE_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(phase_q) != PH_LOW && phase_q == PH_LOW)
      |=> (!en_i || change_o)); // R6
  AST_SAMPLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $fell(drive_low_o)) |-> sample_o); // R7
  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase_q == PH_REL && !scl_i && cnt_q > rise_lim_i)
      |=> (!en_i || cnt_q == $past(cnt_q))); // R8
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int RT_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] clkc_i,
  input  logic             fast_i,
  input  logic             duty_i,
  input  logic             fmp_i,
  input  logic [RT_W-1:0]  rise_i,
  input  logic             scl_i,
  output logic             scl_low_o,
  output logic             sda_change_o,
  output logic             sda_sample_o
);
  localparam int LEN_W = CNT_W + 5; // holds 16*max count

  logic [LEN_W-1:0] low_len, high_len, rise_lim;

  scl_phase_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_calc (
    .clkc_i    (clkc_i),
    .fast_i    (fast_i),
    .duty_i    (duty_i),
    .fmp_i     (fmp_i),
    .low_len_o (low_len),
    .high_len_o(high_len)
  );

  scl_rise_budget #(.RT_W(RT_W), .LEN_W(LEN_W)) u_rise (
    .rise_i    (rise_i),
    .rise_lim_o(rise_lim)
  );

  scl_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .scl_i      (scl_i),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .rise_lim_i (rise_lim),
    .drive_low_o(scl_low_o),
    .change_o   (sda_change_o),
    .sample_o   (sda_sample_o)
  );
endmodule

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;
  localparam int CNT_W = 6;
  localparam int RT_W  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [CNT_W-1:0] clkc = '0;
  logic             fast = 1'b0, duty = 1'b0, fmp = 1'b0;
  logic [RT_W-1:0]  rise = '0;
  logic             scl;
  logic             drv, chg, smp;

  int total = 0, bad = 0;
  int exp_lo = 0, exp_hi = 0, stretch_len = 0, rel_cnt = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_scl_timer #(.CNT_W(CNT_W), .RT_W(RT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clkc_i(clkc), .fast_i(fast),
    .duty_i(duty), .fmp_i(fmp), .rise_i(rise), .scl_i(scl),
    .scl_low_o(drv), .sda_change_o(chg), .sda_sample_o(smp)
  );

  // bus model: released line reads high unless a slave holds it for stretch_len cycles
  always @(posedge clk) rel_cnt <= drv ? 0 : rel_cnt + 1;
  assign scl = !drv && (rel_cnt >= stretch_len);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lo_len(input bit f, input bit d, input int c);
    int cc;
    if (!f) return (c < 4) ? 4 : c;
    cc = (c == 0) ? 1 : c;
    return d ? 16 * cc : 2 * cc;
  endfunction

  function automatic int hi_len(input bit f, input bit d, input int c);
    int cc;
    if (!f) return (c < 4) ? 4 : c;
    cc = (c == 0) ? 1 : c;
    return d ? 9 * cc : cc;
  endfunction

  // run monitor, sampled at the falling edge
  bit prev = 0, started = 0;
  int low_run = 0, rel_run = 0, pre_cnt = 0;
  always @(negedge clk) if (rst_n && !done) begin
    if (!en) begin
      check(!drv && !chg && !smp, "R9 off", {29'd0, drv, chg, smp}, 0);
      started = 0; prev = 0; low_run = 0; rel_run = 0; pre_cnt = 0;
    end else if (!started) begin
      if (drv) begin
        check(pre_cnt == 1, "R5 first low", pre_cnt, 1);
        started = 1; prev = 1; low_run = 1;
        check(!chg && !smp, "R6 strobes", {30'd0, chg, smp}, 0);
      end else begin
        pre_cnt++;
        check(!chg && !smp, "R9 strobes before start", {30'd0, chg, smp}, 0);
      end
    end else begin
      if (drv) begin
        if (!prev) begin
          check(rel_run == exp_hi, {tag, " high"}, rel_run, exp_hi);
          low_run = 1;
        end else low_run++;
        check(chg == (low_run == 2), "R6 change", chg, low_run == 2);
        check(!smp, "R7 sample in low", smp, 0);
      end else begin
        if (prev) begin
          check(low_run == exp_lo, {tag, " low"}, low_run, exp_lo);
          rel_run = 1;
        end else rel_run++;
        check(smp == (rel_run == 1), "R7 sample", smp, rel_run == 1);
        check(!chg, "R6 change in high", chg, 0);
      end
      prev = drv;
    end
  end

  task automatic run_cfg(input bit f, input bit d, input bit fm, input int c,
                         input int r, input int stl, input string t);
    fast = f; duty = d; fmp = fm; clkc = CNT_W'(c); rise = RT_W'(r);
    stretch_len = stl; tag = t;
    exp_lo = lo_len(f, d, c);
    exp_hi = hi_len(f, d, c);
    if (stl > r && exp_hi > r) exp_hi = exp_hi + stl - r;
    en = 1'b1;
    repeat (3 * (exp_lo + exp_hi) + 4) @(posedge clk);
    #1 en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!drv && !chg && !smp, "R9 reset", {29'd0, drv, chg, smp}, 0);
    @(posedge clk); #1;
    for (int m = 0; m < 7; m++) begin
      bit f, d, fm;
      string mt;
      case (m)
        0: begin f = 0; d = 0; fm = 0; mt = "R1"; end
        1: begin f = 0; d = 1; fm = 0; mt = "R1"; end
        2: begin f = 1; d = 0; fm = 0; mt = "R2"; end
        3: begin f = 1; d = 1; fm = 0; mt = "R3"; end
        4: begin f = 1; d = 0; fm = 1; mt = "R4"; end
        5: begin f = 1; d = 1; fm = 1; mt = "R4"; end
        default: begin f = 0; d = 0; fm = 1; mt = "R4"; end
      endcase
      for (int i = 0; i < 12; i++) begin
        int c;
        c = (i < 10) ? i : 52 + i;
        run_cfg(f, d, fm, c, 5, 0, (c == 63) ? "R10" : mt);
      end
    end
    // stretching against the rise budget
    run_cfg(0, 0, 0, 5, 0, 3, "R8");
    run_cfg(0, 0, 0, 5, 2, 4, "R8");
    run_cfg(0, 0, 0, 5, 6, 8, "R8");
    run_cfg(1, 0, 0, 3, 1, 5, "R8");
    run_cfg(1, 1, 0, 2, 3, 7, "R8");
    run_cfg(0, 0, 0, 7, 7, 7, "R8");
    // disable in the middle of a released phase, then restart
    fast = 1; duty = 1; fmp = 0; clkc = 6'd3; rise = 7'd2; stretch_len = 0; tag = "R9";
    exp_lo = 48; exp_hi = 27;
    en = 1'b1;
    repeat (48 + 10) @(posedge clk);
    #1 en = 1'b0;
    @(negedge clk);
    check(!drv && !smp && !chg, "R9 mid-phase release", {29'd0, drv, chg, smp}, 0);
    repeat (2) @(posedge clk); #1;
    run_cfg(1, 1, 0, 3, 2, 0, "R9");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule